// File: doc/BRIEF.md
# TLB Maintenance Command Decoder

This block sits between the system-register write path and a pair of translation lookaside buffers, one for instruction fetch and one for data access. A write to one of the TLB maintenance indices is turned into an invalidate command: the decoder chooses which TLB or TLBs must act, selects one of four operation kinds, and takes the page address and address-space identifier (ASID) out of the 32-bit write value. Writes to any other index pass through without effect.

Each TLB receives a one-cycle request carrying the operation and its fields. The TLB can hold requests off with a busy level, and it reports completion with a one-cycle acknowledge. The decoder drops its ready output from the cycle it accepts a maintenance write until every TLB that the command targets has acknowledged. The register path must hold a write until ready is high. A write offered while ready is low is discarded.

The decoder stores no register value. It keeps only the fields of the command in flight, and it places them on both TLB command buses.

Top module: `tlbm_decoder`

## Requirements
- R1: After reset, `ready` is 1, both request outputs are 0, and the command fields read 0.
- R2: Maintenance indices are `MAINT_BASE + 4*kind + scope`. Kind 0 invalidates everything, 1 invalidates by page and ASID, 2 invalidates by ASID, and 3 invalidates by page for all ASIDs. Scope 0 is the local form (both TLBs), 1 is the inner-shareable form (both TLBs), 2 is instruction only and 3 is data only. Kind 3 exists only with scopes 0 and 1. The output op code equals the kind, and the default base is 16. An invalidate-everything write at scope 0 or 1 raises a request with op 0 on both TLBs.
- R3: A write with scope 2 raises a request only on the instruction TLB. A write with scope 3 raises a request only on the data TLB.
- R4: Kind 1 drives the page field as write bits 31:12 with bits 11:0 zero, and drives the ASID field as write bits 7:0.
- R5: Kind 2 drives the ASID field as write bits 7:0 and drives the page field as 0.
- R6: Kind 3 drives the page field as write bits 31:12 with bits 11:0 zero. The ASID field reads 0 whatever write bits 7:0 hold.
- R7: An inner-shareable write (scope 1) produces the same requests, op and fields as the local write (scope 0) of the same kind and data.
- R8: Kinds 0 and 2 drive the page field as 0, and kind 0 also drives the ASID field as 0.
- R9: `ready` falls in the cycle after a maintenance write is accepted. It rises only after every targeted TLB has acknowledged, so a command for both TLBs waits for both acknowledges.
- R10: A request is never raised while that TLB's busy input is 1. Each accepted command raises exactly one single-cycle request per targeted TLB, once busy is 0.
- R11: A write to an index outside the maintenance set raises no request, keeps `ready` at 1 and leaves the command fields unchanged.
- R12: A write offered while `ready` is 0 is discarded. It raises no request and does not change the command fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_index | input | IDX_W | Register index of the write |
| wr_data | input | DATA_W | Write value |
| ready | output | 1 | High when a new write can be accepted |
| itlb_req | output | 1 | Single-cycle command request to the instruction TLB |
| itlb_op | output | 2 | Operation kind for the instruction TLB |
| itlb_va | output | DATA_W | Page address, page-offset bits zero |
| itlb_asid | output | ASID_W | ASID for the instruction TLB |
| itlb_busy | input | 1 | Instruction TLB cannot take a request |
| itlb_ack | input | 1 | Instruction TLB finished the command |
| dtlb_req | output | 1 | Single-cycle command request to the data TLB |
| dtlb_op | output | 2 | Operation kind for the data TLB |
| dtlb_va | output | DATA_W | Page address, page-offset bits zero |
| dtlb_asid | output | ASID_W | ASID for the data TLB |
| dtlb_busy | input | 1 | Data TLB cannot take a request |
| dtlb_ack | input | 1 | Data TLB finished the command |

## Verification
Two functions can fall into the same cycle. The first is the completion of one TLB, whose acknowledge clears its share of the command. The second is the hold-off of the other TLB, whose busy input still blocks its request, or whose own acknowledge has not yet arrived. The bench provokes this by giving the two TLBs very different acknowledge latencies, and by holding one TLB busy while the other acknowledges. It judges the result from `ready`, which must stay low until the last targeted acknowledge, and from the scoreboard, which must see exactly one request per TLB carrying the expected fields. A second overlap is a new write offered while a command is still pending. That write must vanish without changing the fields.

// File: rtl/tlbm_pkg.sv
// Shared types for the TLB maintenance decoder.
// Assumes two TLB targets: index 0 is instruction, index 1 is data.
package tlbm_pkg;

    // Operation kinds, carried on the op output of each TLB bus.
    typedef enum logic [1:0] {
        TLBM_OP_ALL     = 2'd0,
        TLBM_OP_VA_ASID = 2'd1,
        TLBM_OP_ASID    = 2'd2,
        TLBM_OP_VA_ALL  = 2'd3
    } tlbm_op_e;

    // Scope of a maintenance index: which TLBs take the command.
    typedef enum logic [1:0] {
        TLBM_SC_LOCAL  = 2'd0,
        TLBM_SC_SHARED = 2'd1,
        TLBM_SC_INSTR  = 2'd2,
        TLBM_SC_DATA   = 2'd3
    } tlbm_scope_e;

    localparam int TLBM_NUM_TGT = 2;
    localparam int TLBM_TGT_I   = 0;
    localparam int TLBM_TGT_D   = 1;
    localparam int TLBM_N_CODES = 14;

endpackage

// File: rtl/tlbm_index_decode.sv
// Index decoder: maps a register index to maintenance kind and target mask.
// Assumes the maintenance set is MAINT_BASE + 4*kind + scope, where kind 3
// exists only with the local and inner-shareable scopes (14 codes in all).
module tlbm_index_decode
    import tlbm_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int MAINT_BASE = 16
) (
    input  logic [IDX_W-1:0]        index_i,
    output logic                    maint_o,
    output tlbm_op_e                op_o,
    output logic [TLBM_NUM_TGT-1:0] target_o
);

    localparam logic [IDX_W-1:0] BASE_V  = IDX_W'(MAINT_BASE);
    localparam logic [IDX_W-1:0] NCODE_V = IDX_W'(TLBM_N_CODES);

    logic [IDX_W-1:0] rel;
    tlbm_scope_e      scope;

    // Offset of the index from the start of the maintenance set.
    assign rel = index_i - BASE_V;

    // Membership in the maintenance set.
    assign maint_o = (index_i >= BASE_V) && (rel < NCODE_V);

    // Kind and scope fields of the offset.
    assign op_o  = tlbm_op_e'(rel[3:2]);
    assign scope = tlbm_scope_e'(rel[1:0]);

    // Target mask from scope; inner-shareable acts like local.
    always_comb begin
        target_o = '0;
        if (maint_o) begin
            unique case (scope)
                TLBM_SC_LOCAL,
                TLBM_SC_SHARED: target_o = '1;
                TLBM_SC_INSTR:  target_o[TLBM_TGT_I] = 1'b1;
                TLBM_SC_DATA:   target_o[TLBM_TGT_D] = 1'b1;
                default:        target_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/tlbm_field_extract.sv
// Field extractor: takes the page address and ASID out of the write value
// according to the operation kind. Fields an operation does not use read 0.
// Assumes PAGE_LSB < DATA_W and ASID_W <= PAGE_LSB.
module tlbm_field_extract
    import tlbm_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ASID_W   = 8,
    parameter int PAGE_LSB = 12
) (
    input  tlbm_op_e          op_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] va_o,
    output logic [ASID_W-1:0] asid_o
);

    localparam logic [DATA_W-1:0] PAGE_MASK =
        {{(DATA_W-PAGE_LSB){1'b1}}, {PAGE_LSB{1'b0}}};

    logic use_va;
    logic use_asid;

    // Which fields the operation kind consumes.
    always_comb begin
        use_va   = 1'b0;
        use_asid = 1'b0;
        unique case (op_i)
            TLBM_OP_ALL:     ;
            TLBM_OP_VA_ASID: begin use_va = 1'b1; use_asid = 1'b1; end
            TLBM_OP_ASID:    use_asid = 1'b1;
            TLBM_OP_VA_ALL:  use_va = 1'b1;
            default:         ;
        endcase
    end

    // Page-aligned address and low-byte ASID, zeroed when unused.
    assign va_o   = use_va   ? (data_i & PAGE_MASK) : '0;
    assign asid_o = use_asid ? data_i[ASID_W-1:0]   : '0;

endmodule

// File: rtl/tlbm_port_ctrl.sv
// Per-TLB handshake: holds a command until the TLB is not busy, raises a
// one-cycle request, then waits for the acknowledge.
// Assumes load_i only arrives while pending_o is low.
module tlbm_port_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic busy_i,
    input  logic ack_i,
    output logic req_o,
    output logic pending_o
);

    logic issue_q;
    logic wait_q;

    // Issue and wait flags of the single outstanding command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_q <= 1'b0;
            wait_q  <= 1'b0;
        end else if (load_i) begin
            issue_q <= 1'b1;
            wait_q  <= 1'b0;
        end else begin
            if (issue_q && !busy_i) begin
                issue_q <= 1'b0;
                wait_q  <= 1'b1;
            end
            if (wait_q && ack_i) begin
                wait_q <= 1'b0;
            end
        end
    end

    // Request goes out in the first cycle the TLB is free.
    assign req_o     = issue_q && !busy_i;
    assign pending_o = issue_q || wait_q;

endmodule

// File: rtl/tlbm_decoder.sv
// TLB maintenance command decoder top. It accepts one register write when
// ready, decodes maintenance indices into invalidate commands and hands them
// to the instruction and data TLBs. Assumes single-cycle busy/ack signalling
// from each TLB, with the ack arriving after the request.
module tlbm_decoder
    import tlbm_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int MAINT_BASE = 16,
    parameter int DATA_W     = 32,
    parameter int ASID_W     = 8,
    parameter int PAGE_LSB   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ready,
    output logic              itlb_req,
    output logic [1:0]        itlb_op,
    output logic [DATA_W-1:0] itlb_va,
    output logic [ASID_W-1:0] itlb_asid,
    input  logic              itlb_busy,
    input  logic              itlb_ack,
    output logic              dtlb_req,
    output logic [1:0]        dtlb_op,
    output logic [DATA_W-1:0] dtlb_va,
    output logic [ASID_W-1:0] dtlb_asid,
    input  logic              dtlb_busy,
    input  logic              dtlb_ack
);

    logic                    dec_maint;
    tlbm_op_e                dec_op;
    logic [TLBM_NUM_TGT-1:0] dec_tgt;
    logic [DATA_W-1:0]       ext_va;
    logic [ASID_W-1:0]       ext_asid;

    logic                    accept;
    logic                    load_cmd;
    tlbm_op_e                op_q;
    logic [DATA_W-1:0]       va_q;
    logic [ASID_W-1:0]       asid_q;

    logic [TLBM_NUM_TGT-1:0] busy_v;
    logic [TLBM_NUM_TGT-1:0] ack_v;
    logic [TLBM_NUM_TGT-1:0] req_v;
    logic [TLBM_NUM_TGT-1:0] pend_v;

    tlbm_index_decode #(
        .IDX_W      (IDX_W),
        .MAINT_BASE (MAINT_BASE)
    ) u_dec (
        .index_i  (wr_index),
        .maint_o  (dec_maint),
        .op_o     (dec_op),
        .target_o (dec_tgt)
    );

    tlbm_field_extract #(
        .DATA_W   (DATA_W),
        .ASID_W   (ASID_W),
        .PAGE_LSB (PAGE_LSB)
    ) u_ext (
        .op_i   (dec_op),
        .data_i (wr_data),
        .va_o   (ext_va),
        .asid_o (ext_asid)
    );

    // Write is taken when offered while ready; only maintenance ones load.
    assign accept   = wr_valid && ready;
    assign load_cmd = accept && dec_maint;

    // Command fields of the command in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= TLBM_OP_ALL;
            va_q   <= '0;
            asid_q <= '0;
        end else if (load_cmd) begin
            op_q   <= dec_op;
            va_q   <= ext_va;
            asid_q <= ext_asid;
        end
    end

    assign busy_v[TLBM_TGT_I] = itlb_busy;
    assign busy_v[TLBM_TGT_D] = dtlb_busy;
    assign ack_v[TLBM_TGT_I]  = itlb_ack;
    assign ack_v[TLBM_TGT_D]  = dtlb_ack;

    for (genvar t = 0; t < TLBM_NUM_TGT; t++) begin : g_port
        tlbm_port_ctrl u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load_cmd && dec_tgt[t]),
            .busy_i    (busy_v[t]),
            .ack_i     (ack_v[t]),
            .req_o     (req_v[t]),
            .pending_o (pend_v[t])
        );
    end

    // Ready only when no TLB still owes a request or an acknowledge.
    assign ready = ~|pend_v;

    assign itlb_req  = req_v[TLBM_TGT_I];
    assign itlb_op   = op_q;
    assign itlb_va   = va_q;
    assign itlb_asid = asid_q;
    assign dtlb_req  = req_v[TLBM_TGT_D];
    assign dtlb_op   = op_q;
    assign dtlb_va   = va_q;
    assign dtlb_asid = asid_q;

endmodule

// File: rtl/tlbm_decoder_chk.sv
// Property checker for tlbm_decoder, attached with bind below.
// Assumes the index layout of R2 and the handshake of R9 and R10.
module tlbm_decoder_chk #(
    parameter int IDX_W      = 6,
    parameter int MAINT_BASE = 16,
    parameter int DATA_W     = 32,
    parameter int ASID_W     = 8,
    parameter int PAGE_LSB   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [IDX_W-1:0]  wr_index,
    input logic              ready,
    input logic              itlb_req,
    input logic [1:0]        itlb_op,
    input logic [DATA_W-1:0] itlb_va,
    input logic [ASID_W-1:0] itlb_asid,
    input logic              itlb_busy,
    input logic              itlb_ack,
    input logic              dtlb_req,
    input logic              dtlb_busy,
    input logic              dtlb_ack
);

    logic idx_in_set;
    assign idx_in_set = (int'(wr_index) >= MAINT_BASE) &&
                        (int'(wr_index) < MAINT_BASE + 14);

    // R10: busy blocks the instruction request
    p_ibusy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        itlb_busy |-> !itlb_req);

    // R10: busy blocks the data request
    p_dbusy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dtlb_busy |-> !dtlb_req);

    // R10: instruction request lasts one cycle
    p_ireq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        itlb_req |=> !itlb_req);

    // R10: data request lasts one cycle
    p_dreq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dtlb_req |=> !dtlb_req);

    // R9: a request is only ever seen while the decoder is not ready
    p_req_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (itlb_req || dtlb_req) |-> !ready);

    // R9: without an acknowledge the decoder stays not ready
    p_hold_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !itlb_ack && !dtlb_ack) |=> !ready);

    // R9: an accepted maintenance write drops ready next cycle
    p_accept_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && ready && idx_in_set) |=> !ready);

    // R11: a non-maintenance write keeps ready and raises nothing
    p_nonmaint_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && ready && !idx_in_set) |=> (ready && !itlb_req && !dtlb_req));

    // R12: fields hold while a command is pending
    p_fields_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(itlb_op) && $stable(itlb_va) && $stable(itlb_asid)));

    // R4: page address on a request has a zero page offset
    p_va_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        itlb_req |-> (itlb_va[PAGE_LSB-1:0] == '0));

endmodule

bind tlbm_decoder tlbm_decoder_chk #(
    .IDX_W      (IDX_W),
    .MAINT_BASE (MAINT_BASE),
    .DATA_W     (DATA_W),
    .ASID_W     (ASID_W),
    .PAGE_LSB   (PAGE_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_index  (wr_index),
    .ready     (ready),
    .itlb_req  (itlb_req),
    .itlb_op   (itlb_op),
    .itlb_va   (itlb_va),
    .itlb_asid (itlb_asid),
    .itlb_busy (itlb_busy),
    .itlb_ack  (itlb_ack),
    .dtlb_req  (dtlb_req),
    .dtlb_busy (dtlb_busy),
    .dtlb_ack  (dtlb_ack)
);

// File: tb/tlbm_decoder_tb.sv
`timescale 1ns/1ps
module tlbm_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [5:0]  wr_index = '0;
    logic [31:0] wr_data = '0;
    logic        ready;
    logic        itlb_req, dtlb_req;
    logic [1:0]  itlb_op, dtlb_op;
    logic [31:0] itlb_va, dtlb_va;
    logic [7:0]  itlb_asid, dtlb_asid;
    logic        itlb_busy = 1'b0, dtlb_busy = 1'b0;
    logic        itlb_ack = 1'b0, dtlb_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int i_seen = 0;
    int d_seen = 0;
    int ilat = 1;
    int dlat = 2;
    bit done = 1'b0;

    logic [41:0] i_q[$];
    logic [41:0] d_q[$];
    string       i_tq[$];
    string       d_tq[$];
    logic [41:0] last_item = '0;

    always #2.5 clk = ~clk;

    tlbm_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_index(wr_index),
        .wr_data(wr_data), .ready(ready),
        .itlb_req(itlb_req), .itlb_op(itlb_op), .itlb_va(itlb_va),
        .itlb_asid(itlb_asid), .itlb_busy(itlb_busy), .itlb_ack(itlb_ack),
        .dtlb_req(dtlb_req), .dtlb_op(dtlb_op), .dtlb_va(dtlb_va),
        .dtlb_asid(dtlb_asid), .dtlb_busy(dtlb_busy), .dtlb_ack(dtlb_ack)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Driver: waits for ready, pushes the expected commands, offers the write.
    task automatic do_write(input logic [5:0] idx, input logic [31:0] data,
                            input string tag);
        int rel;
        int kind;
        int sc;
        logic [31:0] va;
        logic [7:0]  asid;
        logic [41:0] item;
        while (!ready) begin @(posedge clk); #1; end
        rel = int'(idx) - 16;
        if (rel >= 0 && rel < 14) begin
            kind = rel / 4;
            sc   = rel % 4;
            va   = (kind == 1 || kind == 3) ? (data & 32'hFFFF_F000) : 32'h0;
            asid = (kind == 1 || kind == 2) ? data[7:0] : 8'h0;
            item = {kind[1:0], va, asid};
            last_item = item;
            if (sc != 3) begin i_q.push_back(item); i_tq.push_back(tag); end
            if (sc != 2) begin d_q.push_back(item); d_tq.push_back(tag); end
        end
        wr_valid = 1'b1; wr_index = idx; wr_data = data;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic drain();
        while (!ready) begin @(posedge clk); #1; end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: pops an expected item for every request and compares it.
    always @(negedge clk) begin
        if (rst_n && itlb_req) begin
            i_seen++;
            if (i_q.size() == 0) begin
                check(1'b0, "R3", "unexpected itlb request", {itlb_op, itlb_va, itlb_asid}, 64'h0);
            end else begin
                logic [41:0] e;
                string tg;
                e = i_q.pop_front(); tg = i_tq.pop_front();
                check({itlb_op, itlb_va, itlb_asid} == e, tg, "itlb command",
                      {itlb_op, itlb_va, itlb_asid}, e);
            end
        end
        if (rst_n && dtlb_req) begin
            d_seen++;
            if (d_q.size() == 0) begin
                check(1'b0, "R3", "unexpected dtlb request", {dtlb_op, dtlb_va, dtlb_asid}, 64'h0);
            end else begin
                logic [41:0] e;
                string tg;
                e = d_q.pop_front(); tg = d_tq.pop_front();
                check({dtlb_op, dtlb_va, dtlb_asid} == e, tg, "dtlb command",
                      {dtlb_op, dtlb_va, dtlb_asid}, e);
            end
        end
    end

    // Instruction TLB model: acknowledges ilat cycles after its request.
    initial forever begin
        @(negedge clk);
        if (rst_n && itlb_req) begin
            repeat (ilat) @(posedge clk);
            #1 itlb_ack = 1'b1;
            @(posedge clk); #1 itlb_ack = 1'b0;
        end
    end

    // Data TLB model: acknowledges dlat cycles after its request.
    initial forever begin
        @(negedge clk);
        if (rst_n && dtlb_req) begin
            repeat (dlat) @(posedge clk);
            #1 dtlb_ack = 1'b1;
            @(posedge clk); #1 dtlb_ack = 1'b0;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", "run did not finish", 64'h0, 64'h1);
            summary();
            $finish;
        end
    end

    initial begin
        int si;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // R1: reset state
        check(ready == 1'b1, "R1", "ready", ready, 1);
        check(itlb_req == 1'b0 && dtlb_req == 1'b0, "R1", "requests", {itlb_req, dtlb_req}, 0);
        check(itlb_va == 0 && itlb_asid == 0 && itlb_op == 0, "R1", "fields",
              {itlb_op, itlb_va, itlb_asid}, 0);

        // R2 / R7: invalidate everything, local and inner-shareable
        do_write(6'd16, 32'hFFFF_FFFF, "R2");
        do_write(6'd17, 32'h1234_5678, "R7");
        // R3: single-target invalidate everything
        do_write(6'd18, 32'h0000_00AA, "R3");
        do_write(6'd19, 32'h0000_00BB, "R3");
        // R4: page and ASID, all scopes
        do_write(6'd20, 32'hDEAD_BEEF, "R4");
        do_write(6'd21, 32'hDEAD_BEEF, "R7");
        do_write(6'd22, 32'h0000_1FFF, "R4");
        do_write(6'd23, 32'hFFFF_F001, "R4");
        // R5: ASID only
        do_write(6'd24, 32'h1234_5678, "R5");
        do_write(6'd25, 32'h8765_43C3, "R7");
        do_write(6'd26, 32'hFFFF_FF01, "R5");
        do_write(6'd27, 32'h0000_0080, "R5");
        // R6: page for all ASIDs
        do_write(6'd28, 32'hCAFE_F0A5, "R6");
        do_write(6'd29, 32'h0000_2FFF, "R7");
        drain();
        check(i_q.size() == 0 && d_q.size() == 0, "R8", "queues drained",
              i_q.size() + d_q.size(), 0);

        // R11: non-maintenance indices
        do_write(6'd30, 32'h1111_1111, "R11");
        check(ready == 1'b1, "R11", "ready after idx 30", ready, 1);
        do_write(6'd3, 32'h2222_2222, "R11");
        check(ready == 1'b1, "R11", "ready after idx 3", ready, 1);
        do_write(6'd63, 32'h3333_3333, "R11");
        cycles(2);
        check({itlb_op, itlb_va, itlb_asid} == last_item, "R11", "fields unchanged",
              {itlb_op, itlb_va, itlb_asid}, last_item);

        // R9: dual target waits for the slower acknowledge
        ilat = 1; dlat = 8;
        do_write(6'd16, 32'h0, "R9");
        check(ready == 1'b0, "R9", "ready after accept", ready, 0);
        cycles(4);
        check(ready == 1'b0, "R9", "ready while data ack owed", ready, 0);
        drain();
        check(ready == 1'b1, "R9", "ready after both acks", ready, 1);
        dlat = 2;

        // R10: busy on instruction TLB holds its request off
        itlb_busy = 1'b1;
        si = i_seen;
        do_write(6'd20, 32'h0ABC_D012, "R10");
        cycles(5);
        check(i_seen == si, "R10", "no itlb request while busy", i_seen, si);
        check(ready == 1'b0, "R10", "not ready while held", ready, 0);
        itlb_busy = 1'b0;
        drain();
        check(i_seen == si + 1, "R10", "one itlb request after busy", i_seen, si + 1);

        // R12: write offered while not ready is dropped
        itlb_busy = 1'b1; dtlb_busy = 1'b1;
        do_write(6'd18, 32'h0, "R12");
        wr_valid = 1'b1; wr_index = 6'd23; wr_data = 32'h5555_5055;
        @(posedge clk); #1;
        wr_valid = 1'b0;
        check(ready == 1'b0, "R12", "still not ready", ready, 0);
        check(itlb_asid == 8'h0 && itlb_op == 2'd0, "R12", "fields kept",
              {itlb_op, itlb_asid}, 0);
        itlb_busy = 1'b0; dtlb_busy = 1'b0;
        drain();
        cycles(12);
        check(i_q.size() == 0 && d_q.size() == 0, "R12", "no extra commands",
              i_q.size() + d_q.size(), 0);
        check(ready == 1'b1, "R12", "ready at end", ready, 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule